// File: doc/BRIEF.md
# Scanline Interrupt Generator

This block watches the raster position of a video timing unit and raises three interrupt pulses. Two are line interrupts. Each has its own programmed line and fires at the start of that line. The third is a position interrupt. It fires at a programmed dot offset inside a line and has three repeat behaviours: once per frame, every N field lines, or every field line.

Programmed lines count in field units. A field line n maps to raster line 2n or 2n+1, chosen by the field flag. When interlacing is on, a target that the raster has already passed moves to the other field. The raster counters, the interrupt controller and any timing arithmetic sit outside the block. Software programs two 32-bit registers through a simple write strobe. After each write, and again after each firing, the block re-arms every interrupt from the current raster position.

Top module: `scanline_irq_gen`

## Requirements
- R1: A write with `wrSel`=0 sets the first line interrupt's field line from `wrData[25:16]` and the second from `wrData[9:0]`. All other data bits are ignored.
- R2: A write with `wrSel`=1 sets the position interrupt's field line from `wrData[9:0]`, its mode from `wrData[13:12]` and its dot offset from `wrData[25:16]`. All other data bits are ignored.
- R3: A field line n targets raster line 2n+`oddField`. When `interlaceEn` is high and that line is at or below `lineCount` at re-arm time, the target becomes 2n+(1-`oddField`).
- R4: A target raster line that is not below `totalLines` disables that interrupt until it is next re-armed.
- R5: A line interrupt pulses in the cycle after one in which `lineCount` equals its target and `dotPos` is 0. The pulse lasts one clock even when the raster holds still.
- R6: The position interrupt fires at `dotPos` equal to its offset. An offset of `lineLen` or more acts as `lineLen`-1.
- R7: Mode 0 fires once per pass of the raster over the programmed line. Mode 3 behaves exactly like mode 0.
- R8: In mode 1, a write aims the interrupt at field line (`lineCount`/2)+N, where N is the line field. Half of `totalLines` is subtracted while the result exceeds that half.
- R9: After each mode-1 firing, the field target advances by N with the same half-frame reduction.
- R10: Mode 2 acts as mode 1 with N fixed at 1, whatever the line field holds.
- R11: A write re-arms its interrupts in the next cycle from the raster position of that cycle. That re-arm takes priority over the re-arm caused by a firing in the same cycle.
- R12: After reset, all outputs are low and no interrupt fires until its register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineCount | input | LINE_W | Current raster line |
| dotPos | input | DOT_W | Current dot position within the line |
| oddField | input | 1 | High during the odd field |
| interlaceEn | input | 1 | Interlaced scan enabled |
| totalLines | input | LINE_W+1 | Raster lines per frame |
| lineLen | input | DOT_W+1 | Dots per line |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0: line-interrupt register, 1: position-interrupt register |
| wrData | input | 32 | Write data |
| vIrq1 | output | 1 | First line interrupt pulse |
| vIrq2 | output | 1 | Second line interrupt pulse |
| hIrq | output | 1 | Position interrupt pulse |

## Verification
The bound assertions check the following on every cycle:
- No pulse lasts longer than one clock.
- Line pulses only follow a cycle with dot 0.
- Position pulses only follow a dot inside the line.
- No pulse follows a raster line at or beyond the frame length.
- Outputs stay quiet under reset.

The field mapping, the opposite-field choice under interlace, the every-N advance with its half-frame wrap and the priority of a write over a re-arm all depend on history. Only the bench scenarios can show these. They compare the pulses cycle by cycle against a behavioural model and check the raster lines at which firings occur.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  localparam int unsigned NUM_IRQ = 3;
  localparam int unsigned IDX_V1  = 0;
  localparam int unsigned IDX_V2  = 1;
  localparam int unsigned IDX_H   = 2;

  // position-interrupt repeat behaviour, as encoded in the register
  typedef enum logic [1:0] {
    HM_FRAME    = 2'd0,
    HM_EVERYN   = 2'd1,
    HM_EVERYLN  = 2'd2,
    HM_FRAMEALT = 2'd3
  } hMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_IRQ-1:0] reload;   // aim at the programmed field line
    logic               hSeed;    // every-N: start from the current raster line
    logic               hAdvance; // every-N: step on from the last target
  } tgtStrobe_t;

endpackage

// File: rtl/scanirq_ctrl.sv
module scanirq_ctrl
  import scanirq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_IRQ-1:0]  hit,
  output tgtStrobe_t          strb,
  output logic [NUM_IRQ-1:0]  irq,
  output logic [LINE_W-1:0]   v1Line,
  output logic [LINE_W-1:0]   v2Line,
  output logic [LINE_W-1:0]   hLine,
  output logic [DOT_W-1:0]    hDot,
  output logic [LINE_W-1:0]   hStep
);

  localparam int unsigned UPPER_LSB = 16;
  localparam int unsigned MODE_LSB  = 12;

  logic [1:0]         hModeRaw;
  hMode_e             hMode;
  logic               hEveryN;
  logic               pendV;
  logic               pendH;
  logic [NUM_IRQ-1:0] hitPrev;
  logic [NUM_IRQ-1:0] fire;
  logic               unusedWrBits;

  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1Line   <= '0;
      v2Line   <= '0;
      hLine    <= '0;
      hDot     <= '0;
      hModeRaw <= '0;
      pendV    <= 1'b0;
      pendH    <= 1'b0;
      hitPrev  <= '0;
      irq      <= '0;
    end else begin
      if (wrEn && !wrSel) begin
        v1Line <= wrData[UPPER_LSB +: LINE_W];
        v2Line <= wrData[0 +: LINE_W];
      end
      if (wrEn && wrSel) begin
        hLine    <= wrData[0 +: LINE_W];
        hModeRaw <= wrData[MODE_LSB +: 2];
        hDot     <= wrData[UPPER_LSB +: DOT_W];
      end
      pendV   <= wrEn && !wrSel;
      pendH   <= wrEn && wrSel;
      hitPrev <= hit;
      irq     <= fire;
    end
  end

  // a pulse marks the first cycle of a match
  assign fire = hit & ~hitPrev;

  assign hMode   = hMode_e'(hModeRaw);
  assign hEveryN = (hMode == HM_EVERYN) || (hMode == HM_EVERYLN);
  assign hStep   = (hMode == HM_EVERYLN) ? LINE_W'(1) : hLine;

  // a pending write wins over a firing re-arm
  always_comb begin
    strb = '0;
    strb.reload[IDX_V1] = pendV || fire[IDX_V1];
    strb.reload[IDX_V2] = pendV || fire[IDX_V2];
    if (pendH) begin
      strb.reload[IDX_H] = !hEveryN;
      strb.hSeed         = hEveryN;
    end else if (fire[IDX_H]) begin
      strb.reload[IDX_H] = !hEveryN;
      strb.hAdvance      = hEveryN;
    end
  end

endmodule

// File: rtl/scanirq_datapath.sv
module scanirq_datapath
  import scanirq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  tgtStrobe_t          strb,
  input  logic [LINE_W-1:0]   lineCount,
  input  logic [DOT_W-1:0]    dotPos,
  input  logic                oddField,
  input  logic                interlaceEn,
  input  logic [LINE_W:0]     totalLines,
  input  logic [DOT_W:0]      lineLen,
  input  logic [LINE_W-1:0]   v1Line,
  input  logic [LINE_W-1:0]   v2Line,
  input  logic [LINE_W-1:0]   hLine,
  input  logic [DOT_W-1:0]    hDot,
  input  logic [LINE_W-1:0]   hStep,
  output logic [NUM_IRQ-1:0]  hit
);

  localparam int unsigned FLD_W = LINE_W + 1;  // field-line target
  localparam int unsigned RAS_W = FLD_W + 1;   // mapped raster line
  localparam int unsigned SUM_W = FLD_W + 1;   // unreduced every-N sum

  logic [LINE_W-1:0]  half;
  logic [FLD_W-1:0]   hField;
  logic [FLD_W-1:0]   hBase;
  logic [SUM_W-1:0]   hSum;
  logic [SUM_W-1:0]   hWrapped;
  logic [DOT_W-1:0]   hDotEff;
  logic [FLD_W-1:0]   srcField [NUM_IRQ];
  logic [DOT_W-1:0]   dotTgt   [NUM_IRQ];
  logic [NUM_IRQ-1:0] loadVec;

  assign half = totalLines[LINE_W:1];

  // every-N arithmetic: base plus step, folded back into 1..half
  assign hBase = strb.hAdvance ? hField : FLD_W'(lineCount >> 1);
  assign hSum  = SUM_W'(hBase) + SUM_W'(hStep);
  assign hWrapped = (half != '0 && hSum > SUM_W'(half))
                  ? ((hSum - SUM_W'(1)) % SUM_W'(half)) + SUM_W'(1)
                  : hSum;

  always_comb begin
    if (lineLen == '0)                    hDotEff = '0;
    else if ((DOT_W+1)'(hDot) >= lineLen) hDotEff = DOT_W'(lineLen - 1'b1);
    else                                  hDotEff = hDot;
  end

  assign srcField[IDX_V1] = FLD_W'(v1Line);
  assign srcField[IDX_V2] = FLD_W'(v2Line);
  assign srcField[IDX_H]  = strb.reload[IDX_H] ? FLD_W'(hLine) : FLD_W'(hWrapped);
  assign dotTgt[IDX_V1]   = '0;
  assign dotTgt[IDX_V2]   = '0;
  assign dotTgt[IDX_H]    = hDotEff;

  assign loadVec[IDX_V1] = strb.reload[IDX_V1];
  assign loadVec[IDX_V2] = strb.reload[IDX_V2];
  assign loadVec[IDX_H]  = strb.reload[IDX_H] || strb.hSeed || strb.hAdvance;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hField <= '0;
    else if (loadVec[IDX_H])  hField <= srcField[IDX_H];
  end

  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_unit
    logic [RAS_W-1:0] evenLn;
    logic [RAS_W-1:0] sameFld;
    logic [RAS_W-1:0] otherFld;
    logic [RAS_W-1:0] cand;
    logic [RAS_W-1:0] tgtLine;
    logic             tgtValid;

    assign evenLn   = {srcField[gi], 1'b0};
    assign sameFld  = evenLn | RAS_W'(oddField);
    assign otherFld = evenLn | RAS_W'(!oddField);
    assign cand     = (interlaceEn && sameFld <= RAS_W'(lineCount)) ? otherFld : sameFld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tgtLine  <= '0;
        tgtValid <= 1'b0;
      end else if (loadVec[gi]) begin
        tgtLine  <= cand;
        tgtValid <= cand < RAS_W'(totalLines);
      end
    end

    assign hit[gi] = tgtValid && (tgtLine == RAS_W'(lineCount)) && (dotPos == dotTgt[gi]);
  end

endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen
  import scanirq_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [DOT_W-1:0]  dotPos,
  input  logic              oddField,
  input  logic              interlaceEn,
  input  logic [LINE_W:0]   totalLines,
  input  logic [DOT_W:0]    lineLen,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [31:0]       wrData,
  output logic              vIrq1,
  output logic              vIrq2,
  output logic              hIrq
);

  tgtStrobe_t         strb;
  logic [NUM_IRQ-1:0] hit;
  logic [NUM_IRQ-1:0] irq;
  logic [LINE_W-1:0]  v1Line;
  logic [LINE_W-1:0]  v2Line;
  logic [LINE_W-1:0]  hLine;
  logic [LINE_W-1:0]  hStep;
  logic [DOT_W-1:0]   hDot;

  scanirq_ctrl #(.LINE_W(LINE_W), .DOT_W(DOT_W), .DATA_W(32)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .hit(hit), .strb(strb), .irq(irq), .v1Line(v1Line), .v2Line(v2Line),
    .hLine(hLine), .hDot(hDot), .hStep(hStep)
  );

  scanirq_datapath #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lineCount(lineCount), .dotPos(dotPos),
    .oddField(oddField), .interlaceEn(interlaceEn), .totalLines(totalLines),
    .lineLen(lineLen), .v1Line(v1Line), .v2Line(v2Line), .hLine(hLine),
    .hDot(hDot), .hStep(hStep), .hit(hit)
  );

  assign vIrq1 = irq[IDX_V1];
  assign vIrq2 = irq[IDX_V2];
  assign hIrq  = irq[IDX_H];

endmodule

// File: rtl/scanline_irq_gen_chk.sv
module scanline_irq_gen_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DOT_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [LINE_W-1:0] lineCount,
  input logic [DOT_W-1:0]  dotPos,
  input logic [LINE_W:0]   totalLines,
  input logic [DOT_W:0]    lineLen,
  input logic              vIrq1,
  input logic              vIrq2,
  input logic              hIrq
);

  assert_single_v1_R5: assert property (@(posedge clk) disable iff (!rstN)
    vIrq1 |=> !vIrq1);
  assert_single_v2_R5: assert property (@(posedge clk) disable iff (!rstN)
    vIrq2 |=> !vIrq2);
  assert_single_h_R5: assert property (@(posedge clk) disable iff (!rstN)
    hIrq |=> !hIrq);

  assert_v1_line_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    vIrq1 |-> $past(dotPos) == '0);
  assert_v2_line_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    vIrq2 |-> $past(dotPos) == '0);

  assert_h_dot_inside_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hIrq && $past(lineLen) != '0) |-> (DOT_W+1)'($past(dotPos)) < $past(lineLen));

  assert_within_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vIrq1 || vIrq2 || hIrq) |-> (LINE_W+1)'($past(lineCount)) < $past(totalLines));

  always @(posedge clk) begin
    if (!rstN) begin
      assert_quiet_reset_R12: assert (!vIrq1 && !vIrq2 && !hIrq);
    end
  end

endmodule

bind scanline_irq_gen scanline_irq_gen_chk #(.LINE_W(LINE_W), .DOT_W(DOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .lineCount(lineCount), .dotPos(dotPos),
  .totalLines(totalLines), .lineLen(lineLen),
  .vIrq1(vIrq1), .vIrq2(vIrq2), .hIrq(hIrq)
);

// File: tb/scanline_irq_gen_tb.sv
module scanline_irq_gen_tb;

  localparam int TOTAL = 21;
  localparam int LLEN  = 8;
  localparam int FRAME = TOTAL * LLEN;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  lineCount = '0;
  logic [9:0]  dotPos = '0;
  logic        oddField = 1'b0;
  logic        interlaceEn = 1'b0;
  logic [10:0] totalLines = 11'(TOTAL);
  logic [10:0] lineLen = 11'(LLEN);
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        vIrq1, vIrq2, hIrq;

  scanline_irq_gen u_dut (
    .clk(clk), .rstN(rstN), .lineCount(lineCount), .dotPos(dotPos),
    .oddField(oddField), .interlaceEn(interlaceEn), .totalLines(totalLines),
    .lineLen(lineLen), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .vIrq1(vIrq1), .vIrq2(vIrq2), .hIrq(hIrq)
  );

  always #4ns clk = ~clk;

  int checks = 0;
  int failures = 0;
  string curTag = "R12";

  // raster generator state
  int  rLine = 0;
  int  rDot = 0;
  bit  stall = 0;

  // observed firings
  int cnt1, cnt2, cntH;
  int first1, first2, dotH;
  int hSeq[3];

  // behavioural reference model
  int mTgt[3];
  bit mVal[3];
  bit mPrev[3];
  bit mExp[3];
  int mHField;
  int rV1, rV2, rHL, rHM, rHD;
  bit pV, pH;

  function automatic void mapField(input int n, input int lc, output int ln, output bit ok);
    int c;
    c = 2 * n + (oddField ? 1 : 0);
    if (interlaceEn && c <= lc) c = 2 * n + (oddField ? 0 : 1);
    ln = c;
    ok = c < int'(totalLines);
  endfunction

  function automatic int foldHalf(input int x);
    int h;
    h = int'(totalLines) / 2;
    if (h > 0) while (x > h) x -= h;
    return x;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mTgt[i] = 0; mVal[i] = 0; mPrev[i] = 0; mExp[i] = 0;
      end
      mHField = 0; rV1 = 0; rV2 = 0; rHL = 0; rHM = 0; rHD = 0; pV = 0; pH = 0;
    end else begin
      bit hitNow[3];
      bit fireNow[3];
      int dotT;
      bit everyN;
      int stepN;
      dotT = (rHD >= int'(lineLen)) ? int'(lineLen) - 1 : rHD;
      hitNow[0] = mVal[0] && int'(lineCount) == mTgt[0] && dotPos == 0;
      hitNow[1] = mVal[1] && int'(lineCount) == mTgt[1] && dotPos == 0;
      hitNow[2] = mVal[2] && int'(lineCount) == mTgt[2] && int'(dotPos) == dotT;
      for (int i = 0; i < 3; i++) begin
        fireNow[i] = hitNow[i] && !mPrev[i];
        mExp[i] = fireNow[i];
        mPrev[i] = hitNow[i];
      end
      if (pV) begin
        mapField(rV1, int'(lineCount), mTgt[0], mVal[0]);
        mapField(rV2, int'(lineCount), mTgt[1], mVal[1]);
      end else begin
        if (fireNow[0]) mapField(rV1, int'(lineCount), mTgt[0], mVal[0]);
        if (fireNow[1]) mapField(rV2, int'(lineCount), mTgt[1], mVal[1]);
      end
      everyN = (rHM == 1) || (rHM == 2);
      stepN = (rHM == 2) ? 1 : rHL;
      if (pH || fireNow[2]) begin
        if (!everyN) mHField = rHL;
        else if (pH) mHField = foldHalf(int'(lineCount) / 2 + stepN);
        else mHField = foldHalf(mHField + stepN);
        mapField(mHField, int'(lineCount), mTgt[2], mVal[2]);
      end
      pV = wrEn && !wrSel;
      pH = wrEn && wrSel;
      if (wrEn && !wrSel) begin
        rV1 = int'(wrData[25:16]); rV2 = int'(wrData[9:0]);
      end
      if (wrEn && wrSel) begin
        rHL = int'(wrData[9:0]); rHM = int'(wrData[13:12]); rHD = int'(wrData[25:16]);
      end
    end
  end

  task automatic cmp(input string name, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", curTag, name, act, exp);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearCounts();
    cnt1 = 0; cnt2 = 0; cntH = 0; first1 = -1; first2 = -1; dotH = -1;
    for (int i = 0; i < 3; i++) hSeq[i] = -1;
  endtask

  task automatic step();
    @(negedge clk);
    if (rstN) begin
      cmp("vIrq1", vIrq1, mExp[0]);
      cmp("vIrq2", vIrq2, mExp[1]);
      cmp("hIrq", hIrq, mExp[2]);
    end
    if (vIrq1 === 1'b1) begin
      if (cnt1 == 0) first1 = rLine;
      cnt1++;
    end
    if (vIrq2 === 1'b1) begin
      if (cnt2 == 0) first2 = rLine;
      cnt2++;
    end
    if (hIrq === 1'b1) begin
      if (cntH < 3) hSeq[cntH] = rLine;
      dotH = rDot;
      cntH++;
    end
    if (!stall) begin
      rDot++;
      if (rDot == LLEN) begin
        rDot = 0;
        rLine++;
        if (rLine == TOTAL) begin
          rLine = 0;
          if (interlaceEn) oddField = ~oddField;
        end
      end
    end
    lineCount = 10'(rLine);
    dotPos = 10'(rDot);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic waitLine(input int ln);
    do step(); while (!(rLine == ln && rDot == 0));
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  bit done = 0;

  initial begin
    int oddAtWr;
    clearCounts();
    // R12: outputs quiet in reset and with nothing programmed
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R12 reset outputs", {vIrq1, vIrq2, hIrq}, 0);
    end
    rstN = 1'b1;
    run(2 * FRAME);
    chk("R12 no pulse before programming", cnt1 + cnt2 + cntH, 0);

    // R1 R3 R5: line 3 and 5 with junk bits -> raster 6 and 10, dot 0
    curTag = "R1";
    waitLine(0); clearCounts();
    wr(1'b0, 32'hFC03_FC05);
    run(FRAME);
    chk("R1 first line irq count", cnt1, 1);
    chk("R3 first line irq at raster 2n", first1, 6);
    chk("R1 second line irq count", cnt2, 1);
    chk("R1 second line irq raster line", first2, 10);

    // R4: field line 12 maps past the frame and stays silent
    curTag = "R4";
    waitLine(0); clearCounts();
    wr(1'b0, (32'd12 << 16) | 32'd9);
    run(2 * FRAME);
    chk("R4 out-of-frame line never fires", cnt1, 0);
    chk("R7 line irq once per frame", cnt2, 2);
    chk("R4 in-frame line raster", first2, 18);

    // R2 R7: mode 0, field line 4, dot 5, junk bits around fields
    curTag = "R2";
    waitLine(0); clearCounts();
    wr(1'b1, 32'hFC05_CC04);
    run(2 * FRAME);
    chk("R7 mode 0 fires once per frame", cntH, 2);
    chk("R2 position irq raster line", hSeq[0], 8);
    chk("R2 position irq dot", dotH, 5);

    // R7: reserved mode 3 acts as mode 0
    curTag = "R7";
    waitLine(0); clearCounts();
    wr(1'b1, (32'd2 << 16) | (32'd3 << 12) | 32'd7);
    run(FRAME);
    chk("R7 mode 3 count", cntH, 1);
    chk("R7 mode 3 raster line", hSeq[0], 14);

    // R6: dot offset past line end clamps to last dot
    curTag = "R6";
    waitLine(0); clearCounts();
    wr(1'b1, (32'd30 << 16) | 32'd3);
    run(FRAME);
    chk("R6 clamped firing count", cntH, 1);
    chk("R6 clamped dot", dotH, LLEN - 1);

    // R8 R9: every 3 field lines, written at raster line 4
    curTag = "R8";
    waitLine(4); clearCounts();
    wr(1'b1, (32'd1 << 16) | (32'd1 << 12) | 32'd3);
    run(2 * FRAME);
    chk("R8 seeded target", hSeq[0], 10);
    chk("R9 advanced target", hSeq[1], 16);
    chk("R9 half-frame wrap", hSeq[2], 2);

    // R10: every line, line field 7 ignored, written at raster line 6
    curTag = "R10";
    waitLine(6); clearCounts();
    wr(1'b1, (32'd2 << 12) | 32'd7);
    run(FRAME);
    chk("R10 first target", hSeq[0], 8);
    chk("R10 second target", hSeq[1], 10);
    chk("R10 third target", hSeq[2], 12);

    // R5: raster held on a target gives one pulse
    curTag = "R5";
    waitLine(18);
    stall = 1; clearCounts();
    run(6);
    chk("R5 single pulse under stall", cnt2, 1);
    stall = 0;

    // R3 R11: interlaced re-arm from raster line 10
    curTag = "R3";
    interlaceEn = 1'b1;
    run(2 * FRAME);
    waitLine(10); clearCounts();
    oddAtWr = oddField ? 1 : 0;
    wr(1'b0, (32'd3 << 16) | 32'd9);
    run(FRAME + 20);
    chk("R3 passed line moves to other field", first1, 6 + (1 - oddAtWr));
    chk("R11 later line stays in current field", first2, 18 + oddAtWr);
    curTag = "R11";
    wr(1'b1, (32'd4 << 16) | (32'd1 << 12) | 32'd2);
    run(3 * FRAME);
    wr(1'b1, (32'd1 << 16) | 32'd5);
    run(2 * FRAME);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule